// File: doc/BRIEF.md
# Cache Block Quadword Wrap Sequencer

This block produces the order in which the eight quadwords of a 64-byte cache block cross a system data bus. The transfer begins at the critical quadword the requester asked for, so that the word it needs arrives first. Each later quadword address comes from combining the start address with the beat position by exclusive-OR. A plain incrementing wrap is not used.

Two transfer modes exist. In single-pumped mode one quadword moves per beat, giving eight beats. In double-pumped mode two quadwords move per bus cycle, giving four cycles. The two quadwords of a pair share address bits [4:3] and take opposite values of bit 5, and the first of the pair keeps the start's bit 5. A start strobe captures the address bits [5:3] and the mode. Each advance pulse then moves to the next beat. A new strobe issued during a transfer abandons it and starts over.

Top module: `qw_wrap_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy_o` and `final_o` are 0.
- R2: In the cycle after `go_i` is sampled high, `busy_o` is 1, `beat_o` is 0 and `qw_o` equals the captured `start_qw_i`. The mode `pair_i` is captured at the same time.
- R3: Single-pumped mode (`pair_i`=0): `qw_o` equals the start bits XOR `beat_o`, and each sampled `step_i` raises `beat_o` by 1.
- R4: Double-pumped mode (`pair_i`=1): `beat_o` moves through 0, 2, 4, 6, rising by 2 per sampled `step_i`. `qw_o` bit 2 (PA bit 5) equals start bit 2, and `qw_o` bits [1:0] (PA [4:3]) equal start bits [1:0] XOR `beat_o`/2.
- R5: `qw2_o` carries the second quadword of the pair. In double-pumped mode it equals `qw_o` with bit 2 inverted. In single-pumped mode it equals `qw_o`.
- R6: `final_o` is 1 exactly when busy on the final beat, which is `beat_o`=7 in single-pumped mode and `beat_o`=6 in double-pumped mode.
- R7: A `step_i` sampled on the final beat clears `busy_o` on the next cycle. `busy_o` then stays 0 until `go_i`.
- R8: `step_i` has no effect while idle, and when `step_i` is low the busy outputs hold their values.
- R9: `go_i` during a transfer takes priority over `step_i` and restarts from the new address and mode at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start strobe: capture address and mode |
| start_qw_i | input | 3 | Critical quadword, PA bits [5:3] |
| pair_i | input | 1 | 1 = double-pumped, 0 = single-pumped |
| step_i | input | 1 | Advance to the next beat |
| qw_o | output | 3 | Current (first) quadword, PA bits [5:3] |
| qw2_o | output | 3 | Second quadword of the pair in double-pumped mode |
| beat_o | output | 3 | Position of `qw_o` within the block |
| busy_o | output | 1 | A transfer is in progress; outputs are meaningful |
| final_o | output | 1 | Current beat is the last one |

## Verification
Every output comes from a register, so the effect of a `go_i` or `step_i` sampled at a rising edge appears one cycle later. Input changes within a cycle never reach the outputs directly. The bench drives inputs and compares outputs on the falling edge. Its model updates on the rising edge from the same inputs, so each comparison reflects exactly the strobes taken at the edge before it. Restart, idle-advance and final-beat cases are placed to fall on chosen beats, and the comparison is made in the cycle right after them.

// File: rtl/qw_wrap_seq.sv
module qw_wrap_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [2:0] start_qw_i,
  input  logic       pair_i,
  input  logic       step_i,
  output logic [2:0] qw_o,
  output logic [2:0] qw2_o,
  output logic [2:0] beat_o,
  output logic       busy_o,
  output logic       final_o
);

  logic [2:0] base_q;
  logic [2:0] idx_q;
  logic       dbl_q;
  logic       busy_q;

  wire [2:0] inc  = dbl_q ? 3'd2 : 3'd1;
  wire       endb = dbl_q ? (idx_q == 3'd6) : (idx_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      dbl_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (go_i) begin
      base_q <= start_qw_i;
      idx_q  <= '0;
      dbl_q  <= pair_i;
      busy_q <= 1'b1;
    end else if (busy_q && step_i) begin
      if (endb) busy_q <= 1'b0;
      else      idx_q  <= idx_q + inc;
    end
  end

  wire [1:0] lo = base_q[1:0] ^ idx_q[2:1];

  assign qw_o    = dbl_q ? {base_q[2], lo} : (base_q ^ idx_q);
  assign qw2_o   = dbl_q ? {~base_q[2], lo} : qw_o;
  assign beat_o  = idx_q;
  assign busy_o  = busy_q;
  assign final_o = busy_q & endb;

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (busy_o && beat_o == 3'd0 && qw_o == $past(start_qw_i)));

  a_r3_r4_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_i && !go_i && !final_o) |=>
      (busy_o && beat_o == $past(beat_o) + ($past(dbl_q) ? 3'd2 : 3'd1)));

  a_r5_pair_bit5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dbl_q) |-> (qw2_o[1:0] == qw_o[1:0] && qw2_o[2] != qw_o[2]));

  a_r6_final_busy: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |-> busy_o);

  a_r7_end_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (final_o && step_i && !go_i) |=> !busy_o);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !go_i) |=> !busy_o);

  a_r8_no_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i && !go_i) |=> ($stable(beat_o) && $stable(qw_o) && busy_o));

endmodule

// File: tb/qw_wrap_seq_bench.sv
module qw_wrap_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_i = 1'b0, pair_i = 1'b0, step_i = 1'b0;
  logic [2:0] start_qw_i = '0;
  logic [2:0] qw_o, qw2_o, beat_o;
  logic busy_o, final_o;

  int checks = 0, errors = 0;
  bit done = 0;

  qw_wrap_seq u_qw_wrap_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .start_qw_i(start_qw_i),
    .pair_i(pair_i), .step_i(step_i), .qw_o(qw_o), .qw2_o(qw2_o),
    .beat_o(beat_o), .busy_o(busy_o), .final_o(final_o));

  always #5 clk = ~clk;

  int m_busy = 0, m_pos = 0, m_base = 0, m_dbl = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_pos  = 0;
    end else if (go_i) begin
      m_busy = 1; m_pos = 0; m_base = start_qw_i; m_dbl = pair_i;
    end else if (m_busy != 0 && step_i) begin
      if (m_pos >= 6 + (m_dbl != 0 ? 0 : 1)) m_busy = 0;
      else m_pos = m_pos + (m_dbl != 0 ? 2 : 1);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_qw();
    if (m_dbl == 0) return m_base ^ m_pos;
    return (m_base & 4) | ((m_base & 3) ^ (m_pos / 2));
  endfunction

  function automatic int exp_qw2();
    if (m_dbl == 0) return exp_qw();
    return exp_qw() ^ 4;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 busy", busy_o, m_busy);
      chk("R6 final", final_o,
          (m_busy != 0 && m_pos == (m_dbl != 0 ? 6 : 7)) ? 1 : 0);
      if (m_busy != 0) begin
        chk(m_dbl != 0 ? "R4 beat" : "R3 beat", beat_o, m_pos);
        chk(m_dbl != 0 ? "R4 qw" : "R3 qw", qw_o, exp_qw());
        chk("R5 qw2", qw2_o, exp_qw2());
      end
    end
  end

  task automatic cyc(input bit g, input int a, input bit d, input bit s);
    @(negedge clk);
    go_i = g; start_qw_i = 3'(a); pair_i = d; step_i = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 final in reset", final_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    @(negedge clk);
    chk("R8 step while idle", busy_o, 0);
    go_i = 1; start_qw_i = 3'd6; pair_i = 0; step_i = 0;
    @(negedge clk);
    go_i = 0;
    chk("R2 busy", busy_o, 1);
    chk("R2 beat", beat_o, 0);
    chk("R2 qw", qw_o, 6);
    repeat (7) begin step_i = 1; @(negedge clk); end
    chk("R3 eighth qw for start 110", qw_o, 1);
    chk("R6 final single", final_o, 1);
    step_i = 0; @(negedge clk);
    chk("R8 hold on final", final_o, 1);
    step_i = 1; @(negedge clk);
    step_i = 0;
    chk("R7 done", busy_o, 0);
    go_i = 1; start_qw_i = 3'd1; pair_i = 1; @(negedge clk);
    go_i = 0; step_i = 1; @(negedge clk);
    chk("R4 beat 2", beat_o, 2);
    chk("R4 qw", qw_o, 3'b000);
    chk("R5 qw2", qw2_o, 3'b100);
    go_i = 1; start_qw_i = 3'd4; pair_i = 0; @(negedge clk);
    go_i = 0; step_i = 0;
    chk("R9 restart beat", beat_o, 0);
    chk("R9 restart qw", qw_o, 4);
    chk("R9 restart mode", qw2_o, 4);
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 13) == 0, int'($urandom % 8), $urandom % 2, ($urandom % 3) != 0);
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule